// File: doc/BRIEF.md
# Video Timing Reference Detector

This block sits in front of a serial video encoder and inspects a 10-bit parallel word stream for timing reference sequences. A sequence is one all-ones word followed by two all-zeros words and then a status word. When the first three words fall within a small tolerance of those extreme values, the block rewrites them to the exact extremes before they leave the block. This clipping reaches back over words that arrived earlier, so the output data runs three accepted words behind the input.

The status word tells start of active video from end of active video. The block reports each found sequence as a one-cycle pulse, together with a flag for its kind. It also keeps a level that shows whether the stream is inside active video. An active-low enable gates the whole detection function. While the enable is released, the block detects nothing and the data passes through unchanged, still with the same three-word delay.

Top module: `trs_detector`

## Requirements
- R1: After reset, wordOut is 000h and trsPulse, savFlag, eavFlag and videoActive are all 0.
- R2: The word accepted with wordValid high appears on wordOut after the clock edge that accepts the third word following it. wordOut changes only on edges where wordValid is high.
- R3: With detectEnN low, three consecutive accepted words form a preamble when they fall in 3FCh..3FFh, then 000h..003h, then 000h..003h. These words leave on wordOut as exactly 3FFh, 000h, 000h.
- R4: The word accepted right after a preamble is the status word. If its bit 6 is 0, then after that edge trsPulse and savFlag are 1 and videoActive is set.
- R5: If bit 6 of the status word is 1, then after that edge trsPulse and eavFlag are 1 and videoActive is cleared.
- R6: The status word and every word outside a preamble leave the block unmodified, including values in 000h..003h and 3FCh..3FFh.
- R7: While detectEnN is high, no sequence is detected. trsPulse, savFlag and eavFlag stay 0, videoActive keeps its value, and the data is not clipped.
- R8: trsPulse, savFlag and eavFlag are high for a single clock cycle, and savFlag and eavFlag are never high together.
- R9: A near-extreme high word followed by a near-zero word and then a word above 003h is not a preamble. Nothing is detected and none of the words is clipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordIn | input | 10 | Parallel video word |
| wordValid | input | 1 | Accepts wordIn on this edge |
| detectEnN | input | 1 | Active-low enable for detection and clipping |
| wordOut | output | 10 | Data delayed by three accepted words, preamble clipped |
| trsPulse | output | 1 | One-cycle pulse when a complete sequence is found |
| savFlag | output | 1 | The found sequence is start of active video |
| eavFlag | output | 1 | The found sequence is end of active video |
| videoActive | output | 1 | Stream is between a start and an end sequence |

## Verification
The bench sends a start sequence whose preamble words all sit off the exact extremes (3FEh, 001h, 002h), which shows that clipping is applied. It then sends an end sequence with exact values, which shows that the status bit picks the flag and drives the active level. Ordinary samples at 001h and 3FEh, and the status word itself, must come through unchanged, which separates clipping of the preamble from blanket clipping of the value ranges. The same preamble sent with the enable released, and a preamble broken on its third word, must both give no pulse and no clipping. An idle cycle in the middle of the stream checks that the delay counts accepted words and not clock cycles.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int PIPE_DEPTH = 3;

  typedef struct packed {
    logic shiftEn;
    logic clipLoad;
  } trsStrobe_t;
endpackage

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int CLIP_SPAN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  trsStrobe_t        strobe,
  output logic              preambleHit,
  output logic [WORD_W-1:0] wordOut
);
  localparam logic [WORD_W-1:0] MAX_WORD   = '1;
  localparam logic [WORD_W-1:0] LOW_LIMIT  = WORD_W'(CLIP_SPAN - 1);
  localparam logic [WORD_W-1:0] HIGH_LIMIT = MAX_WORD - LOW_LIMIT;

  logic [WORD_W-1:0] stg [PIPE_DEPTH];

  // stg[0] is newest; a preamble completes when the incoming word is its third
  assign preambleHit = (stg[1] >= HIGH_LIMIT) && (stg[0] <= LOW_LIMIT) &&
                       (wordIn <= LOW_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut <= '0;
      for (int i = 0; i < PIPE_DEPTH; i++) stg[i] <= '0;
    end else if (strobe.shiftEn) begin
      wordOut <= stg[PIPE_DEPTH-1];
      if (strobe.clipLoad) begin
        stg[2] <= MAX_WORD;
        stg[1] <= '0;
        stg[0] <= '0;
      end else begin
        for (int i = PIPE_DEPTH-1; i > 0; i--) stg[i] <= stg[i-1];
        stg[0] <= wordIn;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(wordOut));

  p_clip_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.clipLoad) |=>
      (stg[2] == MAX_WORD && stg[1] == '0 && stg[0] == '0));
endmodule

// File: rtl/trs_control.sv
module trs_control
  import trs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       detectEnN,
  input  logic       preambleHit,
  input  logic       hBit,
  output trsStrobe_t strobe,
  output logic       trsPulse,
  output logic       savFlag,
  output logic       eavFlag,
  output logic       videoActive
);
  logic armed;

  always_comb begin
    strobe.shiftEn  = wordValid;
    strobe.clipLoad = wordValid && !detectEnN && !armed && preambleHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b0;
      trsPulse    <= 1'b0;
      savFlag     <= 1'b0;
      eavFlag     <= 1'b0;
      videoActive <= 1'b0;
    end else begin
      trsPulse <= 1'b0;
      savFlag  <= 1'b0;
      eavFlag  <= 1'b0;
      if (wordValid) begin
        if (detectEnN) begin
          armed <= 1'b0;
        end else if (armed) begin
          armed       <= 1'b0;
          trsPulse    <= 1'b1;
          savFlag     <= !hBit;
          eavFlag     <= hBit;
          videoActive <= !hBit;
        end else begin
          armed <= preambleHit;
        end
      end
    end
  end

  p_flag_kind_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({savFlag, eavFlag}) && ((savFlag || eavFlag) == trsPulse));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    trsPulse |=> !trsPulse);

  p_sav_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    savFlag |-> videoActive);

  p_eav_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    eavFlag |-> !videoActive);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    detectEnN |=> (!trsPulse && $stable(videoActive)));
endmodule

// File: rtl/trs_detector.sv
module trs_detector
  import trs_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int CLIP_SPAN = 4,
  parameter int H_BIT     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              detectEnN,
  output logic [WORD_W-1:0] wordOut,
  output logic              trsPulse,
  output logic              savFlag,
  output logic              eavFlag,
  output logic              videoActive
);
  trsStrobe_t strobe;
  logic       preambleHit;

  trs_datapath #(.WORD_W(WORD_W), .CLIP_SPAN(CLIP_SPAN)) u_datapath (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .strobe(strobe),
    .preambleHit(preambleHit), .wordOut(wordOut)
  );

  trs_control u_control (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .detectEnN(detectEnN),
    .preambleHit(preambleHit), .hBit(wordIn[H_BIT]), .strobe(strobe),
    .trsPulse(trsPulse), .savFlag(savFlag), .eavFlag(eavFlag),
    .videoActive(videoActive)
  );
endmodule

// File: tb/trs_detector_bench.sv
`timescale 1ns/1ps
module trs_detector_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] wordIn = '0;
  logic       wordValid = 1'b0;
  logic       detectEnN = 1'b0;
  logic [9:0] wordOut;
  logic       trsPulse, savFlag, eavFlag, videoActive;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trs_detector u_trs_detector (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .detectEnN(detectEnN), .wordOut(wordOut), .trsPulse(trsPulse),
    .savFlag(savFlag), .eavFlag(eavFlag), .videoActive(videoActive)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // send one word, then check data and the flag group {trs,sav,eav,active}
  task automatic sendChk(input logic [9:0] w, input logic [9:0] expOut,
                         input logic [3:0] expFlags, input string req);
    @(negedge clk);
    wordIn = w;
    wordValid = 1'b1;
    @(posedge clk);
    #2;
    wordValid = 1'b0;
    check({req, " data"}, wordOut, expOut);
    check({req, " flags"}, {trsPulse, savFlag, eavFlag, videoActive}, expFlags);
  endtask

  task automatic testReset();
    check("R1 data", wordOut, 0);
    check("R1 flags", {trsPulse, savFlag, eavFlag, videoActive}, 0);
  endtask

  task automatic testPassThrough();
    sendChk(10'h111, 10'h000, 4'b0000, "R2");
    sendChk(10'h222, 10'h000, 4'b0000, "R2");
    sendChk(10'h333, 10'h000, 4'b0000, "R2");
    sendChk(10'h001, 10'h111, 4'b0000, "R2");
    sendChk(10'h3FE, 10'h222, 4'b0000, "R2");
    @(negedge clk);
    @(negedge clk);
    check("R2 idle hold", wordOut, 10'h222);
    sendChk(10'h040, 10'h333, 4'b0000, "R2");
    sendChk(10'h050, 10'h001, 4'b0000, "R6 low sample");
    sendChk(10'h060, 10'h3FE, 4'b0000, "R6 high sample");
  endtask

  task automatic testSav();
    sendChk(10'h3FE, 10'h040, 4'b0000, "R3");
    sendChk(10'h001, 10'h050, 4'b0000, "R3");
    sendChk(10'h002, 10'h060, 4'b0000, "R3");
    sendChk(10'h200, 10'h3FF, 4'b1101, "R4");
    sendChk(10'h080, 10'h000, 4'b0001, "R8 R3");
    sendChk(10'h081, 10'h000, 4'b0001, "R3");
    sendChk(10'h082, 10'h200, 4'b0001, "R6 status word");
  endtask

  task automatic testEav();
    sendChk(10'h3FF, 10'h080, 4'b0001, "R5");
    sendChk(10'h000, 10'h081, 4'b0001, "R5");
    sendChk(10'h000, 10'h082, 4'b0001, "R5");
    sendChk(10'h2D8, 10'h3FF, 4'b1010, "R5");
    sendChk(10'h100, 10'h000, 4'b0000, "R8");
    sendChk(10'h101, 10'h000, 4'b0000, "R5");
    sendChk(10'h102, 10'h2D8, 4'b0000, "R6 status word");
  endtask

  task automatic testDisabled();
    detectEnN = 1'b1;
    sendChk(10'h3FD, 10'h100, 4'b0000, "R7");
    sendChk(10'h002, 10'h101, 4'b0000, "R7");
    sendChk(10'h001, 10'h102, 4'b0000, "R7");
    sendChk(10'h200, 10'h3FD, 4'b0000, "R7 no pulse");
    sendChk(10'h110, 10'h002, 4'b0000, "R7 unclipped");
    sendChk(10'h111, 10'h001, 4'b0000, "R7 unclipped");
    sendChk(10'h112, 10'h200, 4'b0000, "R7");
    detectEnN = 1'b0;
  endtask

  task automatic testBroken();
    sendChk(10'h3FD, 10'h110, 4'b0000, "R9");
    sendChk(10'h001, 10'h111, 4'b0000, "R9");
    sendChk(10'h100, 10'h112, 4'b0000, "R9");
    sendChk(10'h200, 10'h3FD, 4'b0000, "R9 no pulse");
    sendChk(10'h120, 10'h001, 4'b0000, "R9 unclipped");
    sendChk(10'h121, 10'h100, 4'b0000, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testPassThrough();
    testSav();
    testEav();
    testDisabled();
    testBroken();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule